// File: doc/BRIEF.md
# Trap Entry and Delegation Controller

This block carries out the architectural state changes that happen when a hart takes an exception or an interrupt. A one-cycle trap request comes in with the full cause value, where the top bit flags an interrupt. It also carries the trap value, the PC of the faulting instruction, the current privilege, the two delegation masks, both trap vector bases, the interrupt-enable stack fields of the status register, the debug break-enable bits and a flag that says the hart is already in debug mode. From these the controller picks one of four paths. It stays in debug mode and jumps to a fixed debug address, or it enters debug mode on a software breakpoint, or the supervisor handles the trap, or the machine level handles it.

One clock after the request, the controller presents a one-cycle commit strobe. With it come the new PC, the new privilege, the data to store (cause, exception PC, trap value, saved vector state, new status stack bits, debug cause and previous privilege) and a write enable for each destination group. The surrounding register file applies all of these in that single cycle. Privilege is encoded as user = 0, supervisor = 1 and machine = 3.

Top module: `trap_entry_ctl`

## Requirements
- R1: A request sampled high on a clock edge produces `commit_o` high for exactly the following cycle, and all outputs are valid in that cycle. There is no commit without a request. After reset every output is zero.
- R2: When `dbg_active_i` is set, a breakpoint (non-interrupt cause code 3) gives PC = debug ROM entry (default 0x800). Any other trap, including an interrupt with code 3, gives PC = debug exception address (default 0x808). All write enables stay low and the privilege is unchanged.
- R3: A breakpoint taken outside debug mode, while the break-enable bit for the current privilege is set, enters debug mode. This raises `dbg_we_o`, sets debug cause 1 and previous privilege = current privilege, sets privilege 3, puts the faulting PC on `epc_o` and sets PC = debug ROM entry.
- R4: A breakpoint whose break-enable bit for the current privilege is clear (bits are separate for machine, supervisor and user) is handled as an ordinary exception.
- R5: The cause code is the cause with its top bit cleared. Interrupts look up `mideleg_i` and exceptions look up `medeleg_i` at bit position = code. A code of XLEN or more is never delegated.
- R6: A trap taken at machine privilege is never handled in supervisor mode, whatever the delegation masks hold.
- R7: Supervisor entry sets PC = `stvec_i` and privilege 1 and raises `s_we_o` and `status_we_o` together. The cause, PC and trap value appear on the outputs unchanged. The status stack updates as previous-supervisor-enable = old supervisor enable, supervisor-previous-privilege = bit 0 of the current privilege, supervisor enable = 0, and the machine fields pass through unchanged.
- R8: Machine entry sets privilege 3 and PC = `mtvec_i` with bit 0 cleared. When bit 0 of `mtvec_i` is set and the trap is an interrupt, 4 × code is added. Exceptions are never offset.
- R9: On machine entry `m_we_o` and `status_we_o` rise. Previous-machine-enable = old machine enable, machine-previous-privilege = current privilege, machine enable = 0, and the supervisor fields pass through unchanged.
- R10: On supervisor or machine entry `vsave_o` carries `vstate_i`, to be stored in the save register of the mode that `s_we_o` / `m_we_o` selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid_i | input | 1 | One-cycle trap request |
| cause_i | input | XLEN | Cause, top bit set for interrupts |
| tval_i | input | XLEN | Trap value |
| epc_i | input | XLEN | PC of the trapping instruction |
| priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| dbg_active_i | input | 1 | Hart already in debug mode |
| brk_en_m_i | input | 1 | Breakpoint enters debug from machine |
| brk_en_s_i | input | 1 | Breakpoint enters debug from supervisor |
| brk_en_u_i | input | 1 | Breakpoint enters debug from user |
| medeleg_i | input | XLEN | Exception delegation mask |
| mideleg_i | input | XLEN | Interrupt delegation mask |
| stvec_i | input | XLEN | Supervisor trap vector |
| mtvec_i | input | XLEN | Machine trap vector base, bit 0 = vectored |
| vstate_i | input | VSTATE_W | Extension vector state to save |
| sie_i | input | 1 | Supervisor interrupt enable |
| spie_i | input | 1 | Supervisor previous enable |
| spp_i | input | 1 | Supervisor previous privilege |
| mie_i | input | 1 | Machine interrupt enable |
| mpie_i | input | 1 | Machine previous enable |
| mpp_i | input | 2 | Machine previous privilege |
| commit_o | output | 1 | One-cycle commit strobe |
| pc_o | output | XLEN | Next PC |
| priv_o | output | 2 | Next privilege |
| s_we_o | output | 1 | Write supervisor cause/epc/tval/vector save |
| m_we_o | output | 1 | Write machine cause/epc/tval/vector save |
| dbg_we_o | output | 1 | Write debug PC, debug cause and previous privilege |
| status_we_o | output | 1 | Write the status stack fields |
| cause_o | output | XLEN | Cause to store |
| epc_o | output | XLEN | Exception PC / debug PC to store |
| tval_o | output | XLEN | Trap value to store |
| vsave_o | output | VSTATE_W | Vector state to store |
| sie_o | output | 1 | New supervisor enable |
| spie_o | output | 1 | New supervisor previous enable |
| spp_o | output | 1 | New supervisor previous privilege |
| mie_o | output | 1 | New machine enable |
| mpie_o | output | 1 | New machine previous enable |
| mpp_o | output | 2 | New machine previous privilege |
| dbg_cause_o | output | 3 | Debug entry cause |
| dbg_prv_o | output | 2 | Privilege before debug entry |

## Verification
A wrong routing decision shows up in the very commit cycle after the request. The wrong one of `s_we_o`, `m_we_o` or `dbg_we_o` rises, or the privilege and PC point at the wrong handler. An index slip in the delegation lookup or in the vector offset shows as a wrong `pc_o` in that same cycle. Status stack errors show as a swapped or uncleared enable bit next to `status_we_o`. Each request is checked against an item queued from the requirements, so an error surfaces within one clock of the request that caused it.

// File: rtl/trap_ctl_pkg.sv
package trap_ctl_pkg;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  typedef enum logic [1:0] {
    ROUTE_DBG_HOLD,
    ROUTE_DBG_ENTER,
    ROUTE_SUPER,
    ROUTE_MACHINE
  } route_e;

  typedef struct packed {
    logic       sie;
    logic       spie;
    logic       spp;
    logic       mie;
    logic       mpie;
    logic [1:0] mpp;
  } stat_t;

endpackage

// File: rtl/trap_route.sv
module trap_route
  import trap_ctl_pkg::*;
#(
  parameter int XLEN     = 64,
  parameter int BRK_CODE = 3
) (
  input  logic [XLEN-1:0] cause_i,
  input  logic [1:0]      priv_i,
  input  logic            dbg_active_i,
  input  logic [2:0]      brk_en_i,     // [2] machine, [1] supervisor, [0] user
  input  logic [XLEN-1:0] medeleg_i,
  input  logic [XLEN-1:0] mideleg_i,
  output route_e          route_o,
  output logic            is_brk_o,
  output logic            is_intr_o,
  output logic [XLEN-1:0] code_o
);

  localparam int              IDX_W  = $clog2(XLEN);
  localparam logic [XLEN-1:0] XLEN_V = XLEN'(XLEN);
  localparam logic [XLEN-1:0] BRK_V  = XLEN'(BRK_CODE);

  logic            brk_allowed;
  logic            low_priv;
  logic            in_range;
  logic [XLEN-1:0] deleg_vec;
  logic            deleg_bit;

  always_comb begin
    is_intr_o = cause_i[XLEN-1];
    code_o    = {1'b0, cause_i[XLEN-2:0]};
    is_brk_o  = !is_intr_o && (code_o == BRK_V);

    unique case (priv_i)
      PRIV_M:  brk_allowed = brk_en_i[2];
      PRIV_S:  brk_allowed = brk_en_i[1];
      PRIV_U:  brk_allowed = brk_en_i[0];
      default: brk_allowed = 1'b0;
    endcase

    low_priv  = (priv_i == PRIV_U) || (priv_i == PRIV_S);
    in_range  = code_o < XLEN_V;
    deleg_vec = is_intr_o ? mideleg_i : medeleg_i;
    deleg_bit = deleg_vec[code_o[IDX_W-1:0]];

    if (dbg_active_i)                     route_o = ROUTE_DBG_HOLD;
    else if (is_brk_o && brk_allowed)     route_o = ROUTE_DBG_ENTER;
    else if (low_priv && in_range && deleg_bit) route_o = ROUTE_SUPER;
    else                                  route_o = ROUTE_MACHINE;
  end

endmodule

// File: rtl/trap_target_pc.sv
module trap_target_pc
  import trap_ctl_pkg::*;
#(
  parameter int              XLEN         = 64,
  parameter logic [XLEN-1:0] DBG_ROM_ADDR = 'h800,
  parameter logic [XLEN-1:0] DBG_EXC_ADDR = 'h808
) (
  input  route_e          route_i,
  input  logic            is_brk_i,
  input  logic            is_intr_i,
  input  logic [XLEN-1:0] code_i,
  input  logic [XLEN-1:0] stvec_i,
  input  logic [XLEN-1:0] mtvec_i,
  output logic [XLEN-1:0] pc_o
);

  logic [XLEN-1:0] m_base;
  logic [XLEN-1:0] m_offs;

  always_comb begin
    m_base = {mtvec_i[XLEN-1:1], 1'b0};
    m_offs = (mtvec_i[0] && is_intr_i) ? {code_i[XLEN-3:0], 2'b00} : '0;
    unique case (route_i)
      ROUTE_DBG_HOLD:  pc_o = is_brk_i ? DBG_ROM_ADDR : DBG_EXC_ADDR;
      ROUTE_DBG_ENTER: pc_o = DBG_ROM_ADDR;
      ROUTE_SUPER:     pc_o = stvec_i;
      default:         pc_o = m_base + m_offs;
    endcase
  end

endmodule

// File: rtl/trap_status_stack.sv
module trap_status_stack
  import trap_ctl_pkg::*;
(
  input  route_e     route_i,
  input  logic [1:0] priv_i,
  input  stat_t      stat_i,
  output stat_t      stat_o,
  output logic       we_o
);

  always_comb begin
    stat_o = stat_i;
    we_o   = 1'b0;
    unique case (route_i)
      ROUTE_SUPER: begin
        stat_o.spie = stat_i.sie;
        stat_o.spp  = priv_i[0];
        stat_o.sie  = 1'b0;
        we_o        = 1'b1;
      end
      ROUTE_MACHINE: begin
        stat_o.mpie = stat_i.mie;
        stat_o.mpp  = priv_i;
        stat_o.mie  = 1'b0;
        we_o        = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/trap_entry_ctl.sv
module trap_entry_ctl
  import trap_ctl_pkg::*;
#(
  parameter int              XLEN          = 64,
  parameter int              VSTATE_W      = 32,
  parameter int              BRK_CODE      = 3,
  parameter logic [2:0]      DBG_SWBP_CODE = 3'd1,
  parameter logic [XLEN-1:0] DBG_ROM_ADDR  = 'h800,
  parameter logic [XLEN-1:0] DBG_EXC_ADDR  = 'h808
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                trap_valid_i,
  input  logic [XLEN-1:0]     cause_i,
  input  logic [XLEN-1:0]     tval_i,
  input  logic [XLEN-1:0]     epc_i,
  input  logic [1:0]          priv_i,
  input  logic                dbg_active_i,
  input  logic                brk_en_m_i,
  input  logic                brk_en_s_i,
  input  logic                brk_en_u_i,
  input  logic [XLEN-1:0]     medeleg_i,
  input  logic [XLEN-1:0]     mideleg_i,
  input  logic [XLEN-1:0]     stvec_i,
  input  logic [XLEN-1:0]     mtvec_i,
  input  logic [VSTATE_W-1:0] vstate_i,
  input  logic                sie_i,
  input  logic                spie_i,
  input  logic                spp_i,
  input  logic                mie_i,
  input  logic                mpie_i,
  input  logic [1:0]          mpp_i,
  output logic                commit_o,
  output logic [XLEN-1:0]     pc_o,
  output logic [1:0]          priv_o,
  output logic                s_we_o,
  output logic                m_we_o,
  output logic                dbg_we_o,
  output logic                status_we_o,
  output logic [XLEN-1:0]     cause_o,
  output logic [XLEN-1:0]     epc_o,
  output logic [XLEN-1:0]     tval_o,
  output logic [VSTATE_W-1:0] vsave_o,
  output logic                sie_o,
  output logic                spie_o,
  output logic                spp_o,
  output logic                mie_o,
  output logic                mpie_o,
  output logic [1:0]          mpp_o,
  output logic [2:0]          dbg_cause_o,
  output logic [1:0]          dbg_prv_o
);

  route_e          route;
  logic            is_brk;
  logic            is_intr;
  logic [XLEN-1:0] code;
  logic [XLEN-1:0] pc_nxt;
  logic [1:0]      priv_nxt;
  stat_t           stat_in;
  stat_t           stat_nxt;
  stat_t           stat_q;
  logic            stat_we_nxt;

  assign stat_in = '{sie: sie_i, spie: spie_i, spp: spp_i,
                     mie: mie_i, mpie: mpie_i, mpp: mpp_i};

  trap_route #(.XLEN(XLEN), .BRK_CODE(BRK_CODE)) route_i (
    .cause_i      (cause_i),
    .priv_i       (priv_i),
    .dbg_active_i (dbg_active_i),
    .brk_en_i     ({brk_en_m_i, brk_en_s_i, brk_en_u_i}),
    .medeleg_i    (medeleg_i),
    .mideleg_i    (mideleg_i),
    .route_o      (route),
    .is_brk_o     (is_brk),
    .is_intr_o    (is_intr),
    .code_o       (code)
  );

  trap_target_pc #(.XLEN(XLEN), .DBG_ROM_ADDR(DBG_ROM_ADDR),
                   .DBG_EXC_ADDR(DBG_EXC_ADDR)) tpc_i (
    .route_i   (route),
    .is_brk_i  (is_brk),
    .is_intr_i (is_intr),
    .code_i    (code),
    .stvec_i   (stvec_i),
    .mtvec_i   (mtvec_i),
    .pc_o      (pc_nxt)
  );

  trap_status_stack stk_i (
    .route_i (route),
    .priv_i  (priv_i),
    .stat_i  (stat_in),
    .stat_o  (stat_nxt),
    .we_o    (stat_we_nxt)
  );

  always_comb begin
    unique case (route)
      ROUTE_DBG_HOLD: priv_nxt = priv_i;
      ROUTE_SUPER:    priv_nxt = PRIV_S;
      default:        priv_nxt = PRIV_M;
    endcase
  end

  // Control strobes: live for exactly the cycle after a request.
  always_ff @(posedge clk) begin
    if (rst) begin
      commit_o    <= 1'b0;
      s_we_o      <= 1'b0;
      m_we_o      <= 1'b0;
      dbg_we_o    <= 1'b0;
      status_we_o <= 1'b0;
    end else begin
      commit_o    <= trap_valid_i;
      s_we_o      <= trap_valid_i && (route == ROUTE_SUPER);
      m_we_o      <= trap_valid_i && (route == ROUTE_MACHINE);
      dbg_we_o    <= trap_valid_i && (route == ROUTE_DBG_ENTER);
      status_we_o <= trap_valid_i && stat_we_nxt;
    end
  end

  // Data payload: loaded on a request, held otherwise.
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o        <= '0;
      priv_o      <= '0;
      cause_o     <= '0;
      epc_o       <= '0;
      tval_o      <= '0;
      vsave_o     <= '0;
      stat_q      <= '0;
      dbg_cause_o <= '0;
      dbg_prv_o   <= '0;
    end else if (trap_valid_i) begin
      pc_o      <= pc_nxt;
      priv_o    <= priv_nxt;
      cause_o   <= cause_i;
      epc_o     <= epc_i;
      tval_o    <= tval_i;
      vsave_o   <= vstate_i;
      stat_q    <= stat_nxt;
      dbg_prv_o <= priv_i;
      if (route == ROUTE_DBG_ENTER) dbg_cause_o <= DBG_SWBP_CODE;
    end
  end

  assign sie_o  = stat_q.sie;
  assign spie_o = stat_q.spie;
  assign spp_o  = stat_q.spp;
  assign mie_o  = stat_q.mie;
  assign mpie_o = stat_q.mpie;
  assign mpp_o  = stat_q.mpp;

  AST_COMMIT_AFTER_REQ: assert property (@(posedge clk) disable iff (rst) commit_o |-> $past(trap_valid_i)); // R1
  AST_WE_NEEDS_COMMIT: assert property (@(posedge clk) disable iff (rst) (s_we_o || m_we_o || dbg_we_o || status_we_o) |-> commit_o); // R1
  AST_DEBUG_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst) (trap_valid_i && dbg_active_i) |=> (commit_o && !s_we_o && !m_we_o && !dbg_we_o && !status_we_o)); // R2
  AST_DEBUG_ENTRY_TARGET: assert property (@(posedge clk) disable iff (rst) dbg_we_o |-> (pc_o == DBG_ROM_ADDR && priv_o == PRIV_M && !status_we_o)); // R3
  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (rst) $onehot0({s_we_o, m_we_o, dbg_we_o})); // R5
  AST_NO_DELEG_FROM_M: assert property (@(posedge clk) disable iff (rst) (trap_valid_i && priv_i == PRIV_M) |=> !s_we_o); // R6
  AST_SUPER_ENTRY: assert property (@(posedge clk) disable iff (rst) s_we_o |-> (priv_o == PRIV_S && !sie_o && status_we_o)); // R7
  AST_MACHINE_ENTRY: assert property (@(posedge clk) disable iff (rst) m_we_o |-> (priv_o == PRIV_M && !mie_o && status_we_o)); // R9

endmodule

// File: tb/trap_entry_ctl_tb_top.sv
`timescale 1ns/1ps
module trap_entry_ctl_tb_top;

  localparam int          XLEN = 64;
  localparam int          VW   = 16;
  localparam logic [63:0] ROM  = 64'h800;
  localparam logic [63:0] EXC  = 64'h808;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic            trap_valid = 1'b0;
  logic [63:0]     cause = '0, tval = '0, epc = '0, medeleg = '0, mideleg = '0;
  logic [63:0]     stvec = '0, mtvec = '0;
  logic [1:0]      prv = '0;
  logic            dbg = 1'b0, bm = 1'b0, bs = 1'b0, bu = 1'b0;
  logic [VW-1:0]   vstate = '0;
  logic [6:0]      st_in = '0;

  logic            commit_o, s_we_o, m_we_o, dbg_we_o, status_we_o;
  logic [63:0]     pc_o, cause_o, epc_o, tval_o;
  logic [1:0]      priv_o, mpp_o, dbg_prv_o;
  logic [VW-1:0]   vsave_o;
  logic            sie_o, spie_o, spp_o, mie_o, mpie_o;
  logic [2:0]      dbg_cause_o;

  trap_entry_ctl #(.XLEN(XLEN), .VSTATE_W(VW), .DBG_ROM_ADDR(ROM),
                   .DBG_EXC_ADDR(EXC)) dut_i (
    .clk(clk), .rst(rst), .trap_valid_i(trap_valid), .cause_i(cause),
    .tval_i(tval), .epc_i(epc), .priv_i(prv), .dbg_active_i(dbg),
    .brk_en_m_i(bm), .brk_en_s_i(bs), .brk_en_u_i(bu),
    .medeleg_i(medeleg), .mideleg_i(mideleg), .stvec_i(stvec), .mtvec_i(mtvec),
    .vstate_i(vstate), .sie_i(st_in[6]), .spie_i(st_in[5]), .spp_i(st_in[4]),
    .mie_i(st_in[3]), .mpie_i(st_in[2]), .mpp_i(st_in[1:0]),
    .commit_o(commit_o), .pc_o(pc_o), .priv_o(priv_o), .s_we_o(s_we_o),
    .m_we_o(m_we_o), .dbg_we_o(dbg_we_o), .status_we_o(status_we_o),
    .cause_o(cause_o), .epc_o(epc_o), .tval_o(tval_o), .vsave_o(vsave_o),
    .sie_o(sie_o), .spie_o(spie_o), .spp_o(spp_o), .mie_o(mie_o),
    .mpie_o(mpie_o), .mpp_o(mpp_o), .dbg_cause_o(dbg_cause_o),
    .dbg_prv_o(dbg_prv_o)
  );

  typedef struct {
    logic [63:0]   pc;
    logic [1:0]    priv;
    logic [3:0]    we;     // {s, m, dbg, status}
    logic [63:0]   cause, epc, tval;
    logic [VW-1:0] vs;
    logic [6:0]    st;     // {sie, spie, spp, mie, mpie, mpp}
    logic [2:0]    dcause;
    logic [1:0]    dprv;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  int   seq   = 0;
  logic sent_q = 1'b0;

  task automatic cmp(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // Driver: applies one request at a negedge and queues the expected result.
  task automatic send(input logic [63:0] c, input logic [1:0] p, input logic in_dbg,
                      input logic [2:0] brk, input logic [63:0] med,
                      input logic [63:0] mid, input logic [63:0] mtv,
                      input logic [6:0] st, input string tag);
    exp_t        e;
    logic        intr;
    logic [63:0] code;
    logic        is_brk;
    logic        brk_ok;
    logic        to_s;
    @(negedge clk);
    seq++;
    cause = c; prv = p; dbg = in_dbg; {bm, bs, bu} = brk;
    medeleg = med; mideleg = mid; mtvec = mtv; st_in = st;
    stvec = 64'h0000_0000_0000_4100;
    epc = 64'h8000_0000 + 64'(seq) * 4;
    tval = 64'hDEAD_0000 + 64'(seq);
    vstate = VW'(16'hA500 + seq);
    trap_valid = 1'b1;

    intr   = c[63];
    code   = {1'b0, c[62:0]};
    is_brk = !intr && code == 64'd3;
    brk_ok = (p == 2'd3 && brk[2]) || (p == 2'd1 && brk[1]) || (p == 2'd0 && brk[0]);
    e.tag = tag; e.cause = c; e.epc = epc; e.tval = tval; e.vs = vstate;
    e.st = st; e.dcause = 3'd1; e.dprv = p;
    if (in_dbg) begin
      e.pc = is_brk ? ROM : EXC; e.priv = p; e.we = 4'b0000;
    end else if (is_brk && brk_ok) begin
      e.pc = ROM; e.priv = 2'd3; e.we = 4'b0010;
    end else begin
      to_s = (p == 2'd0 || p == 2'd1) && code < 64 &&
             (intr ? mid[code[5:0]] : med[code[5:0]]);
      if (to_s) begin
        e.pc = stvec; e.priv = 2'd1; e.we = 4'b1001;
        e.st = {1'b0, st[6], p[0], st[3:0]};
      end else begin
        e.pc = {mtv[63:1], 1'b0} + ((mtv[0] && intr) ? code * 4 : 64'd0);
        e.priv = 2'd3; e.we = 4'b0101;
        e.st = {st[6:4], 1'b0, st[3], p};
      end
    end
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      trap_valid = 1'b0;
    end
  endtask

  always @(posedge clk) sent_q <= rst ? 1'b0 : trap_valid;

  // Monitor: compares each commit against the oldest queued item.
  always @(negedge clk) begin
    if (!rst) begin
      if (sent_q || commit_o) cmp("R1", "commit", 64'(commit_o), 64'(sent_q));
      if (commit_o === 1'b1 && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp(e.tag, "pc", pc_o, e.pc);
        cmp(e.tag, "priv", 64'(priv_o), 64'(e.priv));
        cmp(e.tag, "we{s,m,dbg,st}", 64'({s_we_o, m_we_o, dbg_we_o, status_we_o}), 64'(e.we));
        if (e.we[3] || e.we[2]) begin
          cmp(e.tag, "cause", cause_o, e.cause);
          cmp(e.tag, "epc", epc_o, e.epc);
          cmp(e.tag, "tval", tval_o, e.tval);
          cmp(e.tag, "vsave R10", 64'(vsave_o), 64'(e.vs));
        end
        if (e.we[0])
          cmp(e.tag, "status", 64'({sie_o, spie_o, spp_o, mie_o, mpie_o, mpp_o}), 64'(e.st));
        if (e.we[1]) begin
          cmp(e.tag, "dpc", epc_o, e.epc);
          cmp(e.tag, "dcause", 64'(dbg_cause_o), 64'(e.dcause));
          cmp(e.tag, "dprv", 64'(dbg_prv_o), 64'(e.dprv));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  localparam logic [63:0] INT = 64'h8000_0000_0000_0000;

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cmp("R1", "reset commit", 64'(commit_o), 64'd0);
    cmp("R1", "reset pc", pc_o, 64'd0);
    cmp("R1", "reset we", 64'({s_we_o, m_we_o, dbg_we_o, status_we_o}), 64'd0);
    idle(2);

    // machine privilege, delegation bit set but ignored
    send(64'd2, 2'd3, 0, 3'b000, 64'h4, 64'h0, 64'h2000, 7'b0001000, "R6 R8 R9 R10 m-priv");
    idle(2);
    // user exception delegated
    send(64'd8, 2'd0, 0, 3'b000, 64'h100, 64'h0, 64'h2000, 7'b1001011, "R5 R7 R10 u-deleg");
    idle(1);
    // supervisor exception delegated, previous privilege = 1
    send(64'd13, 2'd1, 0, 3'b000, 64'h2000, 64'h0, 64'h2000, 7'b0111111, "R5 R7 s-deleg");
    idle(1);
    // user exception not delegated
    send(64'd13, 2'd0, 0, 3'b000, 64'h0, 64'hFFFF, 64'h2000, 7'b1110100, "R5 R9 u-nodeleg");
    idle(1);
    // interrupt looks up interrupt mask only
    send(INT | 64'd5, 2'd0, 0, 3'b000, 64'h0, 64'h20, 64'h1001, 7'b1000000, "R5 R7 irq-deleg");
    idle(1);
    send(INT | 64'd5, 2'd0, 0, 3'b000, 64'h20, 64'h0, 64'h1001, 7'b0001000, "R5 R8 irq-vectored");
    idle(1);
    // vectored base, exception: no offset
    send(64'd5, 2'd1, 0, 3'b000, 64'h0, 64'h20, 64'h1001, 7'b0001000, "R8 exc-not-vectored");
    idle(1);
    // interrupt in direct mode
    send(INT | 64'd11, 2'd3, 0, 3'b000, 64'h0, 64'h0, 64'h3000, 7'b0001000, "R8 irq-direct");
    idle(1);
    // code beyond XLEN is never delegated
    send(64'd70, 2'd0, 0, 3'b000, '1, '1, 64'h3000, 7'b0000000, "R5 out-of-range");
    idle(1);
    // breakpoint with supervisor break enable
    send(64'd3, 2'd1, 0, 3'b010, '1, '1, 64'h3000, 7'b1111111, "R3 brk-debug-entry");
    idle(1);
    // breakpoint from machine with machine enable
    send(64'd3, 2'd3, 0, 3'b100, 64'h0, 64'h0, 64'h3000, 7'b0001000, "R3 brk-m-entry");
    idle(1);
    // breakpoint from user, only other enables set
    send(64'd3, 2'd0, 0, 3'b110, 64'h0, 64'h0, 64'h3000, 7'b0001000, "R4 brk-no-enable");
    idle(1);
    send(64'd3, 2'd0, 0, 3'b110, 64'h8, 64'h0, 64'h3000, 7'b1000000, "R4 brk-delegated");
    idle(1);
    // already in debug mode
    send(64'd3, 2'd1, 1, 3'b111, '1, '1, 64'h3000, 7'b1111111, "R2 dbg-brk");
    idle(1);
    send(64'd2, 2'd0, 1, 3'b111, '1, '1, 64'h3000, 7'b1111111, "R2 dbg-exc");
    idle(1);
    send(INT | 64'd3, 2'd3, 1, 3'b111, '1, '1, 64'h3000, 7'b1111111, "R2 dbg-irq3");
    idle(1);
    // back-to-back requests
    send(64'd8, 2'd0, 0, 3'b000, 64'h100, 64'h0, 64'h2000, 7'b1000000, "R1 R7 b2b-a");
    send(INT | 64'd7, 2'd1, 0, 3'b000, 64'h0, 64'h0, 64'h5001, 7'b1001000, "R1 R8 R9 b2b-b");
    send(64'd3, 2'd0, 0, 3'b001, 64'h0, 64'h0, 64'h2000, 7'b0000000, "R1 R3 b2b-c");
    idle(4);

    cmp("R1", "queue drained", 64'(q.size()), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule